// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Write-Back Cache

This block is a two-way set-associative data cache for a core whose addresses are translated in parallel with the cache lookup. The set index and the byte-within-block position come from the virtual address. The stored tags are physical page numbers. The core presents a virtual address with read/write, data and a byte strobe. In the next cycle, or in any later cycle, a translation port supplies the physical page number together with a valid flag. The cache compares that number against both ways of the selected set, and it answers in the same cycle that the translation is valid.

The cache uses write-back with write-allocate. On a miss the core port stays stalled while the cache picks a victim. If the victim is dirty, the cache writes it out on the write-back port. It then fetches the block on the refill port and finishes the access as a hit. Replacement is exact LRU over the two ways of a set.

With 8-byte blocks and 2 KB pages, every set index bit above bit 10 is a virtual page number bit. The block reports how many such bits there are, so that the surrounding system knows whether synonyms can occur. The block does not resolve synonyms.

Top module: `vipt_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `cpu_rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0, and every way of every set is invalid, so the first access to any set misses.
- R2: A request is taken in a cycle with `cpu_req_valid` and `cpu_ready` both high. From the next cycle `cpu_ready` stays 0. No response is given in a cycle where `xl_valid` is 0 and no miss is in progress. `cpu_ready` returns to 1 in the cycle after the response.
- R3: The set index is `cpu_req_vaddr[11:3]` (default sizes). A lookup hits when a valid way holds a tag equal to `xl_ppn`. A hit returns the stored 64-bit block on `cpu_rsp_rdata` with `cpu_rsp_valid` high in that same cycle, and it causes no memory traffic.
- R4: A write hit replaces byte i, which is bits 8i+7..8i, exactly when `cpu_req_be[i]` is 1. Every other byte keeps its value, and the way becomes dirty.
- R5: On a miss, the victim is an invalid way if there is one, and way 0 is chosen when both ways are invalid. Otherwise the victim is the least recently used way.
- R6: Every hit and every fill makes the way it used the most recently used way of its set.
- R7: When the victim is valid and dirty, `mem_wr_req` rises with block address {victim tag, vaddr[10:3]} and the victim data. These stay steady until `mem_wr_ack`, and the refill request starts only after the acknowledge.
- R8: When the victim is clean or invalid, no write-back is made.
- R9: A refill raises `mem_rd_req` with block address {ppn, vaddr[10:3]}, held until `mem_rd_valid`. The block is installed clean under that tag, and the stalled access completes as a hit in the next cycle, with writes merged after the fill.
- R10: `va_idx_hi_bits` gives the number of index bits above the page offset. The value is 1 at the default of 512 sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised on release |
| cpu_req_valid | input | 1 | Core request valid |
| cpu_req_vaddr | input | 20 | Virtual byte address |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_wdata | input | 64 | Write data for the block |
| cpu_req_be | input | 8 | Byte strobe for writes |
| cpu_ready | output | 1 | Cache can take a request |
| cpu_rsp_valid | output | 1 | Access completes this cycle |
| cpu_rsp_rdata | output | 64 | Block contents before any write merge |
| xl_valid | input | 1 | Translation result valid |
| xl_ppn | input | 9 | Physical page number |
| mem_rd_req | output | 1 | Refill request |
| mem_rd_addr | output | 17 | Refill physical block address |
| mem_rd_valid | input | 1 | Refill data valid, ends the request |
| mem_rd_data | input | 64 | Refill block data |
| mem_wr_req | output | 1 | Write-back request |
| mem_wr_addr | output | 17 | Write-back physical block address |
| mem_wr_data | output | 64 | Write-back block data |
| mem_wr_ack | input | 1 | Write-back accepted |
| va_idx_hi_bits | output | 4 | Count of index bits taken from the virtual page number |

## Verification
The assertions check on every cycle that request and address are held steady on both memory ports until the handshake, that a write-back is always followed by the refill, and that a finished refill is followed by a hit. They also check that a dirty way is always valid, that at most one way matches, and that the core port drops ready after taking a request. Only the bench scenarios can show that the returned data is right, that byte strobes merge the correct bytes, and that victims follow the invalid-first and LRU order over sequences of hits and fills. The bench's reference model tracks tags, dirty bits, LRU state and a backing memory to check these.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WB   = 2'd2,
    ST_FILL = 2'd3
  } vc_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int SETS  = 512,
  parameter int IDX_W = 9,
  parameter int PPN_W = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   fill_en,
  input  logic                   fill_way,
  input  logic [PPN_W-1:0]       fill_tag,
  input  logic                   dirty_en,
  input  logic                   dirty_way,
  input  logic                   touch_en,
  input  logic                   touch_way,
  output logic [1:0]             vld_o,
  output logic [1:0]             drt_o,
  output logic                   lru_o,
  output logic [1:0][PPN_W-1:0]  tag_o
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic [PPN_W-1:0] tag_q [SETS];
    logic             fill_w;
    logic             dirty_w;

    assign fill_w  = fill_en  && (fill_way  == 1'(w));
    assign dirty_w = dirty_en && (dirty_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (fill_w) begin
        vld_q[idx] <= 1'b1;
        drt_q[idx] <= 1'b0;
      end else if (dirty_w) begin
        drt_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_w) tag_q[idx] <= fill_tag;
    end

    assign vld_o[w] = vld_q[idx];
    assign drt_o[w] = drt_q[idx];
    assign tag_o[w] = tag_q[idx];

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      drt_o[w] |-> vld_o[w]); // R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q      <= '0;
    else if (touch_en) lru_q[idx] <= ~touch_way;
  end

  assign lru_o = lru_q[idx];

  AST_FILL_NOT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && dirty_en)); // R9
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int SETS  = 512,
  parameter int IDX_W = 9,
  parameter int NB    = 8
) (
  input  logic                    clk,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    wr_en,
  input  logic                    wr_way,
  input  logic [NB-1:0]           wr_be,
  input  logic [8*NB-1:0]         wr_data,
  output logic [1:0][8*NB-1:0]    rd_data
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [8*NB-1:0] blk_q [SETS];
    logic            wen;

    assign wen = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk) begin
      if (wen) begin
        for (int b = 0; b < NB; b++) begin
          if (wr_be[b]) blk_q[idx][8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
    end

    assign rd_data[w] = blk_q[idx];
  end
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
#(
  parameter int VA_W  = 20,
  parameter int PG_W  = 11,
  parameter int BO_W  = 3,
  parameter int IDX_W = 9,
  parameter int PPN_W = 9,
  parameter int NB    = 8,
  localparam int DW     = 8 * NB,
  localparam int INPG_W = PG_W - BO_W,
  localparam int BA_W   = PPN_W + INPG_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req_valid,
  input  logic [VA_W-1:0]        cpu_req_vaddr,
  input  logic                   cpu_req_we,
  input  logic [DW-1:0]          cpu_req_wdata,
  input  logic [NB-1:0]          cpu_req_be,
  output logic                   cpu_ready,
  output logic                   cpu_rsp_valid,
  output logic [DW-1:0]          cpu_rsp_rdata,
  input  logic                   xl_valid,
  input  logic [PPN_W-1:0]       xl_ppn,
  output logic                   mem_rd_req,
  output logic [BA_W-1:0]        mem_rd_addr,
  input  logic                   mem_rd_valid,
  input  logic [DW-1:0]          mem_rd_data,
  output logic                   mem_wr_req,
  output logic [BA_W-1:0]        mem_wr_addr,
  output logic [DW-1:0]          mem_wr_data,
  input  logic                   mem_wr_ack,
  output logic [IDX_W-1:0]       set_idx,
  input  logic [1:0]             ts_vld,
  input  logic [1:0]             ts_drt,
  input  logic                   ts_lru,
  input  logic [1:0][PPN_W-1:0]  ts_tag,
  output logic                   fill_en,
  output logic                   fill_way,
  output logic [PPN_W-1:0]       fill_tag,
  output logic                   dirty_en,
  output logic                   dirty_way,
  output logic                   touch_en,
  output logic                   touch_way,
  input  logic [1:0][DW-1:0]     ds_rd,
  output logic                   ds_we,
  output logic                   ds_way,
  output logic [NB-1:0]          ds_be,
  output logic [DW-1:0]          ds_wdata
);
  vc_state_e        st_q, st_d;
  logic [VA_W-1:0]  va_q;
  logic             we_q;
  logic [DW-1:0]    wd_q;
  logic [NB-1:0]    be_q;
  logic [PPN_W-1:0] ppn_q;
  logic             ppn_ok_q;
  logic             vict_q;

  logic             accept;
  logic             eff_vld;
  logic [PPN_W-1:0] eff_ppn;
  logic [1:0]       hit_w;
  logic             hit;
  logic             hit_way;
  logic             vict_d;
  logic             look_go;
  logic             miss_go;
  logic [INPG_W-1:0] inpg;

  assign cpu_ready = (st_q == ST_IDLE);
  assign accept    = cpu_req_valid && cpu_ready;
  assign set_idx   = va_q[BO_W +: IDX_W];
  assign inpg      = va_q[BO_W +: INPG_W];

  // lookup against the translated page number
  always_comb begin
    eff_vld = ppn_ok_q || xl_valid;
    eff_ppn = ppn_ok_q ? ppn_q : xl_ppn;
    for (int w = 0; w < 2; w++) begin
      hit_w[w] = ts_vld[w] && (ts_tag[w] == eff_ppn);
    end
    hit     = |hit_w;
    hit_way = hit_w[1];
    if (!ts_vld[0])      vict_d = 1'b0;
    else if (!ts_vld[1]) vict_d = 1'b1;
    else                 vict_d = ts_lru;
    look_go = (st_q == ST_LOOK) && eff_vld;
    miss_go = look_go && !hit;
  end

  assign cpu_rsp_valid = look_go && hit;
  assign cpu_rsp_rdata = ds_rd[hit_way];

  // store update controls
  assign fill_en   = (st_q == ST_FILL) && mem_rd_valid;
  assign fill_way  = vict_q;
  assign fill_tag  = ppn_q;
  assign dirty_en  = cpu_rsp_valid && we_q;
  assign dirty_way = hit_way;
  assign touch_en  = cpu_rsp_valid || fill_en;
  assign touch_way = fill_en ? vict_q : hit_way;

  always_comb begin
    if (fill_en) begin
      ds_we    = 1'b1;
      ds_way   = vict_q;
      ds_be    = '1;
      ds_wdata = mem_rd_data;
    end else begin
      ds_we    = dirty_en;
      ds_way   = hit_way;
      ds_be    = be_q;
      ds_wdata = wd_q;
    end
  end

  // memory side
  assign mem_wr_req  = (st_q == ST_WB);
  assign mem_wr_addr = {ts_tag[vict_q], inpg};
  assign mem_wr_data = ds_rd[vict_q];
  assign mem_rd_req  = (st_q == ST_FILL);
  assign mem_rd_addr = {ppn_q, inpg};

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_LOOK;
      ST_LOOK: begin
        if (cpu_rsp_valid)                     st_d = ST_IDLE;
        else if (miss_go && ts_vld[vict_d] && ts_drt[vict_d]) st_d = ST_WB;
        else if (miss_go)                      st_d = ST_FILL;
      end
      ST_WB:   if (mem_wr_ack)   st_d = ST_FILL;
      ST_FILL: if (mem_rd_valid) st_d = ST_LOOK;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ppn_ok_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept)       ppn_ok_q <= 1'b0;
      else if (miss_go) ppn_ok_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      va_q <= cpu_req_vaddr;
      we_q <= cpu_req_we;
      wd_q <= cpu_req_wdata;
      be_q <= cpu_req_be;
    end
    if (miss_go) begin
      ppn_q  <= eff_ppn;
      vict_q <= vict_d;
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_ready) |=> !cpu_ready); // R2
  AST_RSP_NEEDS_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> (xl_valid || ppn_ok_q)); // R2
  AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_w)); // R5
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (!mem_rd_req && !mem_wr_req)); // R1
  AST_NO_DUAL_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req)); // R7
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R7
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack) |=> mem_rd_req); // R7
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R9
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid) |=> cpu_rsp_valid); // R9
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int VA_W      = 20,
  parameter int PG_W      = 11,
  parameter int BLK_BYTES = 8,
  parameter int SETS      = 512,
  parameter int PPN_W     = 9
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        cpu_req_valid,
  input  logic [VA_W-1:0]                             cpu_req_vaddr,
  input  logic                                        cpu_req_we,
  input  logic [8*BLK_BYTES-1:0]                      cpu_req_wdata,
  input  logic [BLK_BYTES-1:0]                        cpu_req_be,
  output logic                                        cpu_ready,
  output logic                                        cpu_rsp_valid,
  output logic [8*BLK_BYTES-1:0]                      cpu_rsp_rdata,
  input  logic                                        xl_valid,
  input  logic [PPN_W-1:0]                            xl_ppn,
  output logic                                        mem_rd_req,
  output logic [PPN_W+PG_W-$clog2(BLK_BYTES)-1:0]     mem_rd_addr,
  input  logic                                        mem_rd_valid,
  input  logic [8*BLK_BYTES-1:0]                      mem_rd_data,
  output logic                                        mem_wr_req,
  output logic [PPN_W+PG_W-$clog2(BLK_BYTES)-1:0]     mem_wr_addr,
  output logic [8*BLK_BYTES-1:0]                      mem_wr_data,
  input  logic                                        mem_wr_ack,
  output logic [3:0]                                  va_idx_hi_bits
);
  localparam int BO_W   = $clog2(BLK_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int NB     = BLK_BYTES;
  localparam int DW     = 8 * NB;
  localparam int INPG_W = PG_W - BO_W;
  localparam int HI_W   = (IDX_W > INPG_W) ? (IDX_W - INPG_W) : 0;

  logic [IDX_W-1:0]       set_idx;
  logic [1:0]             ts_vld, ts_drt;
  logic                   ts_lru;
  logic [1:0][PPN_W-1:0]  ts_tag;
  logic                   fill_en, fill_way, dirty_en, dirty_way, touch_en, touch_way;
  logic [PPN_W-1:0]       fill_tag;
  logic [1:0][DW-1:0]     ds_rd;
  logic                   ds_we, ds_way;
  logic [NB-1:0]          ds_be;
  logic [DW-1:0]          ds_wdata;

  assign va_idx_hi_bits = 4'(HI_W);

  vipt_ctrl #(
    .VA_W(VA_W), .PG_W(PG_W), .BO_W(BO_W), .IDX_W(IDX_W), .PPN_W(PPN_W), .NB(NB)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_vaddr(cpu_req_vaddr), .cpu_req_we(cpu_req_we),
    .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be), .cpu_ready(cpu_ready),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .xl_valid(xl_valid), .xl_ppn(xl_ppn),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .set_idx(set_idx), .ts_vld(ts_vld), .ts_drt(ts_drt), .ts_lru(ts_lru), .ts_tag(ts_tag),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
    .dirty_en(dirty_en), .dirty_way(dirty_way), .touch_en(touch_en), .touch_way(touch_way),
    .ds_rd(ds_rd), .ds_we(ds_we), .ds_way(ds_way), .ds_be(ds_be), .ds_wdata(ds_wdata)
  );

  vipt_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(set_idx),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
    .dirty_en(dirty_en), .dirty_way(dirty_way), .touch_en(touch_en), .touch_way(touch_way),
    .vld_o(ts_vld), .drt_o(ts_drt), .lru_o(ts_lru), .tag_o(ts_tag)
  );

  vipt_data_store #(.SETS(SETS), .IDX_W(IDX_W), .NB(NB)) u_data (
    .clk(clk), .idx(set_idx), .wr_en(ds_we), .wr_way(ds_way), .wr_be(ds_be),
    .wr_data(ds_wdata), .rd_data(ds_rd)
  );
endmodule

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic [19:0] cpu_req_vaddr = '0;
  logic        cpu_req_we = 1'b0;
  logic [63:0] cpu_req_wdata = '0;
  logic [7:0]  cpu_req_be = '0;
  logic        cpu_ready, cpu_rsp_valid;
  logic [63:0] cpu_rsp_rdata;
  logic        xl_valid = 1'b0;
  logic [8:0]  xl_ppn = '0;
  logic        mem_rd_req, mem_wr_req;
  logic [16:0] mem_rd_addr, mem_wr_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic [63:0] mem_wr_data;
  logic        mem_wr_ack = 1'b0;
  logic [3:0]  va_idx_hi_bits;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          m_vld [2][512];
  bit          m_drt [2][512];
  logic [8:0]  m_tag [2][512];
  logic [63:0] m_dat [2][512];
  bit          m_lru [512];
  logic [63:0] backing [int];

  always #4 clk = ~clk;

  vipt_cache u_vipt_cache (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_val(input int a);
    if (backing.exists(a)) return backing[a];
    return {32'(a) * 32'h9E3779B1, ~32'(a)};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic access(input logic [19:0] va, input bit we, input logic [63:0] wd,
                        input logic [7:0] be, input logic [8:0] ppn, input int tdly);
    int          idx;
    int          hw;
    int          v;
    bit          exp_wb;
    bit          exp_fill;
    int          wb_addr;
    int          fill_addr;
    logic [63:0] wb_data;
    logic [63:0] exp_rd;
    bit          got;
    bit          seen_wb;
    bit          seen_fill;
    idx = int'(va[11:3]);
    hw = -1;
    exp_wb = 0; exp_fill = 0; wb_addr = 0; wb_data = '0;
    for (int w = 0; w < 2; w++) if (m_vld[w][idx] && m_tag[w][idx] == ppn) hw = w;
    fill_addr = int'({ppn, va[10:3]});
    if (hw < 0) begin
      if (!m_vld[0][idx])      v = 0;
      else if (!m_vld[1][idx]) v = 1;
      else                     v = int'(m_lru[idx]);
      if (m_vld[v][idx] && m_drt[v][idx]) begin
        exp_wb  = 1;
        wb_addr = int'({m_tag[v][idx], va[10:3]});
        wb_data = m_dat[v][idx];
        backing[wb_addr] = wb_data;
      end
      exp_fill = 1;
      m_dat[v][idx] = mem_val(fill_addr);
      m_vld[v][idx] = 1; m_drt[v][idx] = 0; m_tag[v][idx] = ppn;
      hw = v;
    end
    exp_rd = m_dat[hw][idx];
    if (we) begin
      for (int b = 0; b < 8; b++) if (be[b]) m_dat[hw][idx][8*b +: 8] = wd[8*b +: 8];
      m_drt[hw][idx] = 1;
    end
    m_lru[idx] = (hw == 0);

    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req_valid = 1; cpu_req_vaddr = va; cpu_req_we = we; cpu_req_wdata = wd; cpu_req_be = be;
    @(negedge clk);
    cpu_req_valid = 0;
    for (int i = 0; i < tdly; i++) begin
      #1;
      chk(!cpu_rsp_valid && !cpu_ready && !mem_rd_req && !mem_wr_req,
          "R2 waiting for translation", {61'd0, cpu_rsp_valid, cpu_ready, mem_rd_req}, 64'd0);
      @(negedge clk);
    end
    xl_valid = 1; xl_ppn = ppn;
    got = 0; seen_wb = 0; seen_fill = 0;
    for (int n = 0; n < 50 && !got; n++) begin
      #1;
      if (cpu_rsp_valid) begin
        got = 1;
        chk(cpu_rsp_rdata == exp_rd, "R3 R4 response data", cpu_rsp_rdata, exp_rd);
        chk(seen_fill == exp_fill, "R5 R6 hit or miss outcome", 64'(seen_fill), 64'(exp_fill));
        chk(seen_wb == exp_wb, "R7 R8 write-back presence", 64'(seen_wb), 64'(exp_wb));
      end else begin
        if (cpu_ready) chk(0, "R2 ready before response", 64'(cpu_ready), 64'd0);
        if (mem_wr_req) begin
          if (!seen_wb) begin
            chk(int'(mem_wr_addr) == wb_addr, "R7 write-back address", 64'(mem_wr_addr), 64'(wb_addr));
            chk(mem_wr_data == wb_data, "R7 write-back data", mem_wr_data, wb_data);
          end
          seen_wb = 1;
          mem_wr_ack = 1;
        end else if (mem_rd_req) begin
          if (!seen_fill) begin
            chk(int'(mem_rd_addr) == fill_addr, "R9 refill address", 64'(mem_rd_addr), 64'(fill_addr));
            chk(seen_wb == exp_wb, "R7 write-back before refill", 64'(seen_wb), 64'(exp_wb));
          end
          seen_fill = 1;
          mem_rd_valid = 1;
          mem_rd_data = mem_val(int'(mem_rd_addr));
        end
        @(negedge clk);
        mem_wr_ack = 0; mem_rd_valid = 0;
      end
    end
    if (!got) chk(0, "R2 response timeout", 64'd0, 64'd1);
    @(negedge clk);
    xl_valid = 0;
    #1;
    chk(cpu_ready, "R2 ready after response", 64'(cpu_ready), 64'd1);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cpu_ready && !cpu_rsp_valid && !mem_rd_req && !mem_wr_req, "R1 reset outputs",
        {60'd0, cpu_ready, cpu_rsp_valid, mem_rd_req, mem_wr_req}, 64'h8);
    rst_n = 1;
    @(negedge clk); #1;
    chk(va_idx_hi_bits == 4'd1, "R10 index bits above page", 64'(va_idx_hi_bits), 64'd1);
    // cold miss, way 0, then hit
    access(20'h0_0028, 0, '0, '0, 9'd3, 0);                           // R1 R9 R5
    access(20'h0_0028, 0, '0, '0, 9'd3, 2);                           // R3 R2
    access(20'h0_0028, 1, 64'h1122_3344_5566_7788, 8'h0F, 9'd3, 0);   // R4
    access(20'h0_0028, 0, '0, '0, 9'd3, 1);                           // R4 readback
    access(20'h0_0028, 0, '0, '0, 9'd4, 0);                           // R5 way 1 invalid
    access(20'h0_0028, 0, '0, '0, 9'd3, 0);                           // R6 way 0 recent
    access(20'h0_0028, 0, '0, '0, 9'd5, 0);                           // R8 clean evict
    access(20'h0_0028, 0, '0, '0, 9'd6, 0);                           // R7 dirty evict
    access(20'h0_0828, 1, 64'hA5A5_0000_FFFF_1234, 8'hC3, 9'd6, 3);   // R9 write miss, alias set
    access(20'h0_0828, 0, '0, '0, 9'd6, 0);                           // R3
    for (int k = 0; k < 400; k++) begin
      logic [19:0] va;
      va = 20'($urandom);
      va[2:0] = '0;
      va[10:3] = 8'($urandom_range(0, 2));
      access(va, 1'($urandom), {$urandom, $urandom}, 8'($urandom), 9'($urandom_range(0, 4)),
             int'($urandom_range(0, 2)));
    end
    finish_run();
  end
endmodule